// File: doc/BRIEF.md
# Quad DAC SPI Command Core

This block is the digital heart of a four-channel, 12-bit voltage-output converter. A host drives 24-bit command frames into it over an SPI slave port (clock idles high, data sampled on the falling clock edge, chip-select active low). Each frame is an 8-bit command byte followed by a 16-bit data word, both sent most significant bit first. The block is resynchronised to a system clock: the serial clock, chip-select and data pins pass through two-flop synchronisers and are edge-detected, and a complete frame is acted on once chip-select returns high.

Every channel has two registers: an input CODE register written by the host and a DAC latch whose value drives the analog converter. A channel in latched mode moves CODE into the latch only on a load command or while the load input is held low; a channel in transparent mode has its latch follow CODE. The block also keeps a 2-bit power mode per channel, a per-channel latch mode and a 3-bit reference setting, all visible as outputs. An active-low clear input and software clear/reset commands return the registers to their defaults.

The serial receiver is a three-state machine: `RX_IDLE` (chip-select high, waiting), `RX_SHIFT` (chip-select low, shifting one bit per falling serial-clock edge) and `RX_EMIT` (one system-clock cycle presenting a full frame). Transitions: `RX_IDLE`→`RX_SHIFT` on a chip-select fall; `RX_SHIFT`→`RX_EMIT` on a chip-select rise after exactly 24 bits; `RX_SHIFT`→`RX_IDLE` on a chip-select rise after any other count; `RX_EMIT`→`RX_SHIFT` if chip-select falls again at once, otherwise `RX_EMIT`→`RX_IDLE`.

Top module: `quad_dac_core`

## Requirements
- R1: A frame is acted on only when exactly 24 falling serial-clock edges occurred while chip-select was low; a frame of any other length changes nothing. Bits are taken MSB first: bits 23:16 are the command byte, bits 15:0 the data word, and the 12-bit code is data bits 15:4.
- R2: Command high nibble 0x0 writes CODE of the selected channels without touching a latched channel's DAC output; high nibble 0x1 copies CODE into the selected DAC latches.
- R3: The command low nibble selects channel 0..3 (A..D); values 4 to 15 select all four channels.
- R4: High nibble 0x2 writes CODE of the selected channels and then loads every DAC latch; high nibble 0x3 writes CODE and loads the same selected latches.
- R5: Command 0x80 writes CODE of all channels, 0x81 loads all DAC latches from CODE, 0x82 writes all CODE and loads all latches.
- R6: Command 0x40..0x43 sets the 2-bit power mode (command bits 1:0) of each channel whose bit is set in data bits 11:8 (bit 8 = channel A); other channels keep their mode. `pwr_mode[2i+1:2i]` is channel i.
- R7: Commands 0x60/0x61 make the channels masked by data bits 11:8 latched/transparent; 0x68/0x69 make all channels latched/transparent. `xparent[i]`=1 means transparent; a transparent channel's DAC output equals its CODE.
- R8: Commands 0x70..0x77 load the reference setting: command bit 2 to `ref_always_on`, bits 1:0 to `ref_select`.
- R9: Command 0x50 zeroes all CODE and DAC registers; 0x51 does the same and also sets all power modes to 00, all channels latched and the reference setting to 000.
- R10: While `ldac_n` is low, every DAC latch takes the value of its CODE register.
- R11: While `clr_n` is low, every CODE and DAC register is zero.
- R12: Command bytes outside the sets above (e.g. 0x44..0x4F, 0x52..0x5F, 0x62..0x67, 0x6A..0x6F, 0x78..0x7F, 0x83..0xFF) change no state.
- R13: After reset all DAC outputs, power modes, latch modes and the reference setting are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Active-low load of all DAC latches from CODE |
| clr_n | input | 1 | Active-low clear of CODE and DAC registers |
| dac_out | output | 48 | DAC latch values, channel i in bits 12i+11:12i |
| pwr_mode | output | 8 | Power mode per channel (00 normal, 01 1k pulldown, 10 100k pulldown, 11 high impedance) |
| xparent | output | 4 | Latch mode per channel, 1 = transparent |
| ref_always_on | output | 1 | Reference kept powered regardless of channel power |
| ref_select | output | 2 | Reference source (00 external, 01 2.500 V, 10 2.048 V, 11 4.096 V) |

## Verification
CODE registers are not ports, so a corrupted CODE value appears only when a load, a load-input pulse or a switch to transparent mode moves it to `dac_out`; the bench therefore follows every ignored or short frame with a load-all command to expose hidden damage. A wrong bit count or a miscounted frame length shows up as a DAC or mode output changing about four system cycles after chip-select rises when it should not, or not changing when it should. Mode and reference faults appear on their outputs in the cycle after the frame is presented, and a stuck synchroniser on the clear or load input shows within three cycles of the pin moving.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    localparam int CMD_W   = 8;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = CMD_W + WORD_W;

    // Command groups carried in the upper command nibble.
    localparam logic [3:0] GRP_WRITE     = 4'h0;
    localparam logic [3:0] GRP_LOAD      = 4'h1;
    localparam logic [3:0] GRP_WR_LD_ALL = 4'h2;
    localparam logic [3:0] GRP_WR_LD_SEL = 4'h3;
    localparam logic [3:0] GRP_POWER     = 4'h4;
    localparam logic [3:0] GRP_CLEAR     = 4'h5;
    localparam logic [3:0] GRP_LATCH     = 4'h6;
    localparam logic [3:0] GRP_REF       = 4'h7;
    localparam logic [3:0] GRP_BCAST     = 4'h8;

    // Position of the channel mask inside the data word.
    localparam int MASK_LSB = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_EMIT  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/qdac_spi_rx.sv
module qdac_spi_rx
    import quad_dac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame_bits
);

    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_SAT = FRAME_BITS + 1;

    // Two-flop synchronisers plus one history flop for edge detection.
    logic [1:0] sclk_sync;
    logic [1:0] cs_sync;
    logic [1:0] mosi_sync;
    logic       sclk_hist;
    logic       cs_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= 2'b11;
            cs_sync   <= 2'b11;
            mosi_sync <= 2'b00;
            sclk_hist <= 1'b1;
            cs_hist   <= 1'b1;
        end else begin
            sclk_sync <= {sclk_sync[0], sclk};
            cs_sync   <= {cs_sync[0], cs_n};
            mosi_sync <= {mosi_sync[0], mosi};
            sclk_hist <= sclk_sync[1];
            cs_hist   <= cs_sync[1];
        end
    end

    logic sclk_fall;
    logic cs_fall;
    logic cs_rise;

    assign sclk_fall = sclk_hist & ~sclk_sync[1];
    assign cs_fall   = cs_hist & ~cs_sync[1];
    assign cs_rise   = ~cs_hist & cs_sync[1];

    rx_state_t           state_q;
    rx_state_t           state_d;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [FRAME_BITS-1:0] shift_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (cs_fall) state_d = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (cs_rise) begin
                    if (bit_cnt_q == CNT_W'(FRAME_BITS)) state_d = RX_EMIT;
                    else                                 state_d = RX_IDLE;
                end
            end
            RX_EMIT: begin
                if (cs_fall) state_d = RX_SHIFT;
                else         state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers driven by the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else if (cs_fall) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else if (state_q == RX_SHIFT && sclk_fall && !cs_sync[1]) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], mosi_sync[1]};
            if (bit_cnt_q != CNT_W'(CNT_SAT)) bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    assign frame_valid = (state_q == RX_EMIT);
    assign frame_bits  = shift_q;

endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import quad_dac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int RES = 12
) (
    input  logic              valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [WORD_W-1:0] data,
    output logic [NCH-1:0]    wr_mask,
    output logic [NCH-1:0]    ld_mask,
    output logic [RES-1:0]    wr_code,
    output logic [NCH-1:0]    pwr_mask,
    output logic [1:0]        pwr_val,
    output logic [NCH-1:0]    lat_mask,
    output logic              lat_val,
    output logic              ref_we,
    output logic [2:0]        ref_val,
    output logic              soft_clr,
    output logic              soft_rst
);

    localparam logic [NCH-1:0] ALL_CH = {NCH{1'b1}};

    logic [3:0]     grp;
    logic [3:0]     sub;
    logic [NCH-1:0] sel_mask;
    logic [NCH-1:0] field_mask;
    logic           unused_bits;

    assign grp        = cmd[7:4];
    assign sub        = cmd[3:0];
    assign wr_code    = data[WORD_W-1 -: RES];
    assign field_mask = data[MASK_LSB +: NCH];
    assign unused_bits = ^data;

    // Channel index below NCH picks one channel, anything else picks all.
    always_comb begin
        if (32'(sub) < NCH) sel_mask = NCH'(1) << sub;
        else                sel_mask = ALL_CH;
    end

    always_comb begin
        wr_mask  = '0;
        ld_mask  = '0;
        pwr_mask = '0;
        pwr_val  = 2'b00;
        lat_mask = '0;
        lat_val  = 1'b0;
        ref_we   = 1'b0;
        ref_val  = 3'b000;
        soft_clr = 1'b0;
        soft_rst = 1'b0;
        if (valid) begin
            case (grp)
                GRP_WRITE:     wr_mask = sel_mask;
                GRP_LOAD:      ld_mask = sel_mask;
                GRP_WR_LD_ALL: begin
                    wr_mask = sel_mask;
                    ld_mask = ALL_CH;
                end
                GRP_WR_LD_SEL: begin
                    wr_mask = sel_mask;
                    ld_mask = sel_mask;
                end
                GRP_POWER: begin
                    if (sub[3:2] == 2'b00) begin
                        pwr_mask = field_mask;
                        pwr_val  = sub[1:0];
                    end
                end
                GRP_CLEAR: begin
                    if (sub == 4'h0) soft_clr = 1'b1;
                    if (sub == 4'h1) soft_rst = 1'b1;
                end
                GRP_LATCH: begin
                    case (sub)
                        4'h0: begin lat_mask = field_mask; lat_val = 1'b0; end
                        4'h1: begin lat_mask = field_mask; lat_val = 1'b1; end
                        4'h8: begin lat_mask = ALL_CH;     lat_val = 1'b0; end
                        4'h9: begin lat_mask = ALL_CH;     lat_val = 1'b1; end
                        default: ;
                    endcase
                end
                GRP_REF: begin
                    if (!sub[3]) begin
                        ref_we  = 1'b1;
                        ref_val = sub[2:0];
                    end
                end
                GRP_BCAST: begin
                    case (sub)
                        4'h0: wr_mask = ALL_CH;
                        4'h1: ld_mask = ALL_CH;
                        4'h2: begin wr_mask = ALL_CH; ld_mask = ALL_CH; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RES-1:0] wr_code,
    input  logic           ld_en,
    input  logic           ldac_act,
    input  logic           clr,
    input  logic           xp_next,
    output logic [RES-1:0] dac_q
);

    logic [RES-1:0] code_q;
    logic [RES-1:0] code_d;
    logic [RES-1:0] dac_d;

    // Latch input uses the CODE value after this cycle's write, so a
    // write-and-load lands the new value in one step.
    always_comb begin
        if (clr)        code_d = '0;
        else if (wr_en) code_d = wr_code;
        else            code_d = code_q;

        if (clr)                             dac_d = '0;
        else if (xp_next || ld_en || ldac_act) dac_d = code_d;
        else                                 dac_d = dac_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            dac_q  <= '0;
        end else begin
            code_q <= code_d;
            dac_q  <= dac_d;
        end
    end

endmodule

// File: rtl/quad_dac_core.sv
module quad_dac_core
    import quad_dac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int RES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic             ldac_n,
    input  logic             clr_n,
    output logic [NCH*RES-1:0] dac_out,
    output logic [2*NCH-1:0] pwr_mode,
    output logic [NCH-1:0]   xparent,
    output logic             ref_always_on,
    output logic [1:0]       ref_select
);

    logic               frame_valid;
    logic [FRAME_W-1:0] frame_bits;
    logic [CMD_W-1:0]   frame_cmd;
    logic [WORD_W-1:0]  frame_word;

    qdac_spi_rx #(.FRAME_BITS(FRAME_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .frame_valid (frame_valid),
        .frame_bits  (frame_bits)
    );

    assign frame_cmd  = frame_bits[FRAME_W-1 -: CMD_W];
    assign frame_word = frame_bits[WORD_W-1:0];

    // Synchronisers for the asynchronous load and clear pins.
    logic [1:0] ldac_pipe;
    logic [1:0] clr_pipe;
    logic       ldac_sync;
    logic       clr_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldac_pipe <= 2'b11;
            clr_pipe  <= 2'b11;
        end else begin
            ldac_pipe <= {ldac_pipe[0], ldac_n};
            clr_pipe  <= {clr_pipe[0], clr_n};
        end
    end

    assign ldac_sync = ldac_pipe[1];
    assign clr_sync  = clr_pipe[1];

    logic [NCH-1:0] wr_mask;
    logic [NCH-1:0] ld_mask;
    logic [RES-1:0] wr_code;
    logic [NCH-1:0] pwr_mask;
    logic [1:0]     pwr_val;
    logic [NCH-1:0] lat_mask;
    logic           lat_val;
    logic           ref_we;
    logic [2:0]     ref_val;
    logic           soft_clr;
    logic           soft_rst;

    qdac_cmd_decode #(.NCH(NCH), .RES(RES)) u_dec (
        .valid    (frame_valid),
        .cmd      (frame_cmd),
        .data     (frame_word),
        .wr_mask  (wr_mask),
        .ld_mask  (ld_mask),
        .wr_code  (wr_code),
        .pwr_mask (pwr_mask),
        .pwr_val  (pwr_val),
        .lat_mask (lat_mask),
        .lat_val  (lat_val),
        .ref_we   (ref_we),
        .ref_val  (ref_val),
        .soft_clr (soft_clr),
        .soft_rst (soft_rst)
    );

    // Control registers.
    logic [NCH-1:0]   xp_q;
    logic [NCH-1:0]   xp_d;
    logic [2*NCH-1:0] pwr_q;
    logic [2:0]       ref_q;

    always_comb begin
        if (soft_rst) xp_d = '0;
        else          xp_d = (xp_q & ~lat_mask) | (lat_mask & {NCH{lat_val}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xp_q  <= '0;
            pwr_q <= '0;
            ref_q <= '0;
        end else begin
            xp_q <= xp_d;
            if (soft_rst)    ref_q <= '0;
            else if (ref_we) ref_q <= ref_val;
            for (int i = 0; i < NCH; i++) begin
                if (soft_rst)         pwr_q[2*i +: 2] <= 2'b00;
                else if (pwr_mask[i]) pwr_q[2*i +: 2] <= pwr_val;
            end
        end
    end

    logic clr_any;
    assign clr_any = soft_clr | soft_rst | ~clr_sync;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        qdac_channel #(.RES(RES)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_mask[g]),
            .wr_code  (wr_code),
            .ld_en    (ld_mask[g]),
            .ldac_act (~ldac_sync),
            .clr      (clr_any),
            .xp_next  (xp_d[g]),
            .dac_q    (dac_out[g*RES +: RES])
        );
    end

    assign pwr_mode      = pwr_q;
    assign xparent       = xp_q;
    assign ref_always_on = ref_q[2];
    assign ref_select    = ref_q[1:0];

endmodule

// File: rtl/quad_dac_core_checker.sv
module quad_dac_core_checker #(
    parameter int NCH = 4,
    parameter int RES = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_n,
    input logic               frame_valid,
    input logic [7:0]         frame_cmd,
    input logic               ldac_sync,
    input logic               clr_sync,
    input logic [NCH*RES-1:0] dac_out,
    input logic [2*NCH-1:0]   pwr_mode,
    input logic [NCH-1:0]     xparent,
    input logic               ref_always_on,
    input logic [1:0]         ref_select
);

    // R1: a presented frame lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R2: DAC outputs move only after a frame, a load pulse or a clear
    a_r2_dac_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_out) |-> ($past(frame_valid) || !$past(ldac_sync) || !$past(clr_sync)));

    // R6: power modes move only after a frame
    a_r6_pwr_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_mode) |-> $past(frame_valid));

    // R7: latch modes move only after a frame
    a_r7_mode_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xparent) |-> $past(frame_valid));

    // R8: reference setting moves only after a frame
    a_r8_ref_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_always_on, ref_select}) |-> $past(frame_valid));

    // R9: software reset leaves every register at its default
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_valid) && $past(frame_cmd) == 8'h51) |->
        (dac_out == '0 && pwr_mode == '0 && xparent == '0 &&
         !ref_always_on && ref_select == 2'b00));

    // R11: clear pin held low for three samples forces zero outputs
    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_n) && !$past(clr_n, 2) && !$past(clr_n, 3)) |-> dac_out == '0);

endmodule

bind quad_dac_core quad_dac_core_checker #(.NCH(NCH), .RES(RES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_n         (clr_n),
    .frame_valid   (frame_valid),
    .frame_cmd     (frame_cmd),
    .ldac_sync     (ldac_sync),
    .clr_sync      (clr_sync),
    .dac_out       (dac_out),
    .pwr_mode      (pwr_mode),
    .xparent       (xparent),
    .ref_always_on (ref_always_on),
    .ref_select    (ref_select)
);

// File: tb/quad_dac_core_bench.sv
`timescale 1ns/1ps
module quad_dac_core_bench;

    localparam int NCH = 4;
    localparam int RES = 12;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic ldac_n = 1'b1;
    logic clr_n = 1'b1;
    logic [NCH*RES-1:0] dac_out;
    logic [2*NCH-1:0]   pwr_mode;
    logic [NCH-1:0]     xparent;
    logic               ref_always_on;
    logic [1:0]         ref_select;

    always #2.5 clk = ~clk;

    quad_dac_core #(.NCH(NCH), .RES(RES)) u_quad_dac_core (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
        .ldac_n (ldac_n), .clr_n (clr_n), .dac_out (dac_out), .pwr_mode (pwr_mode),
        .xparent (xparent), .ref_always_on (ref_always_on), .ref_select (ref_select)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [RES-1:0] m_code [NCH];
    logic [RES-1:0] m_dac  [NCH];
    logic [1:0]     m_pwr  [NCH];
    logic           m_xp   [NCH];
    logic [2:0]     m_ref;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_code[i] = '0; m_dac[i] = '0; m_pwr[i] = 2'b00; m_xp[i] = 1'b0;
        end
        m_ref = 3'b000;
    endtask

    task automatic model_follow();
        for (int i = 0; i < NCH; i++) if (m_xp[i]) m_dac[i] = m_code[i];
    endtask

    // Expected effect of one accepted frame, written from the requirements.
    task automatic model_cmd(input logic [7:0] c, input logic [15:0] d);
        logic [3:0] sel;
        logic [3:0] msk;
        logic [RES-1:0] v;
        v   = d[15:4];
        msk = d[11:8];
        sel = (c[3:0] < 4) ? (4'b0001 << c[3:0]) : 4'b1111;
        if (c[7:4] <= 4'h3) begin
            for (int i = 0; i < NCH; i++) begin
                if (sel[i] && c[7:4] != 4'h1) m_code[i] = v;
            end
            for (int i = 0; i < NCH; i++) begin
                if ((c[7:4] == 4'h1 || c[7:4] == 4'h3) && sel[i]) m_dac[i] = m_code[i];
                if (c[7:4] == 4'h2) m_dac[i] = m_code[i];
            end
        end else if (c[7:2] == 6'b010000) begin
            for (int i = 0; i < NCH; i++) if (msk[i]) m_pwr[i] = c[1:0];
        end else if (c == 8'h50) begin
            for (int i = 0; i < NCH; i++) begin m_code[i] = '0; m_dac[i] = '0; end
        end else if (c == 8'h51) begin
            model_reset();
        end else if (c == 8'h60 || c == 8'h61) begin
            for (int i = 0; i < NCH; i++) if (msk[i]) m_xp[i] = c[0];
        end else if (c == 8'h68 || c == 8'h69) begin
            for (int i = 0; i < NCH; i++) m_xp[i] = c[0];
        end else if (c[7:3] == 5'b01110) begin
            m_ref = c[2:0];
        end else if (c == 8'h80 || c == 8'h82) begin
            for (int i = 0; i < NCH; i++) m_code[i] = v;
            if (c == 8'h82) for (int i = 0; i < NCH; i++) m_dac[i] = m_code[i];
        end else if (c == 8'h81) begin
            for (int i = 0; i < NCH; i++) m_dac[i] = m_code[i];
        end
        model_follow();
    endtask

    task automatic send_bits(input logic [7:0] c, input logic [15:0] d, input int nbits);
        logic [31:0] word;
        word = {8'h00, c, d};
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            if (b < 24) mosi = word[23-b];
            else        mosi = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send(input logic [7:0] c, input logic [15:0] d);
        send_bits(c, d, 24);
        model_cmd(c, d);
    endtask

    task automatic check_all(input string tag);
        logic [NCH*RES-1:0] e_dac;
        logic [2*NCH-1:0]   e_pwr;
        logic [NCH-1:0]     e_xp;
        for (int i = 0; i < NCH; i++) begin
            e_dac[i*RES +: RES] = m_dac[i];
            e_pwr[2*i +: 2]     = m_pwr[i];
            e_xp[i]             = m_xp[i];
        end
        tests++;
        if (dac_out !== e_dac || pwr_mode !== e_pwr || xparent !== e_xp ||
            {ref_always_on, ref_select} !== m_ref) begin
            fails++;
            $display("FAIL %s: dac=%h exp=%h pwr=%h exp=%h xp=%h exp=%h ref=%h exp=%h",
                     tag, dac_out, e_dac, pwr_mode, e_pwr, xparent, e_xp,
                     {ref_always_on, ref_select}, m_ref);
        end
    endtask

    function automatic logic [7:0] pick_cmd();
        logic [7:0] c;
        case ($urandom_range(0, 9))
            0, 1, 2: c = {2'b00, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            3:       c = {6'b010000, 2'($urandom_range(0, 3))};
            4:       c = ($urandom_range(0, 1) == 0) ? {7'b0110000, 1'($urandom_range(0, 1))}
                                                     : {7'b0110100, 1'($urandom_range(0, 1))};
            5:       c = {5'b01110, 3'($urandom_range(0, 7))};
            6:       c = 8'($urandom_range(8'h80, 8'h82));
            7:       c = ($urandom_range(0, 5) == 0) ? 8'h51 : 8'h50;
            default: c = 8'($urandom_range(0, 255));
        endcase
        return c;
    endfunction

    initial begin
        void'($urandom(32'h0001_D4C5));
        model_reset();
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check_all("R13 reset state");

        // R2 write CODE does not reach a latched DAC, load does
        send(8'h01, 16'hABC0);
        check_all("R2 write only");
        send(8'h11, 16'h0000);
        check_all("R2 load selected");
        // R3 index above 3 selects every channel
        send(8'h0F, 16'h1230);
        send(8'h1C, 16'h0000);
        check_all("R3 all select");
        // R4 write-and-load variants
        send(8'h22, 16'h4560);
        check_all("R4 write sel load all");
        send(8'h33, 16'hFFF0);
        check_all("R4 write sel load sel");
        // R5 broadcasts
        send(8'h80, 16'h0010);
        check_all("R5 write all");
        send(8'h81, 16'h0000);
        check_all("R5 load all");
        send(8'h82, 16'h7770);
        check_all("R5 write load all");
        // R6 masked power
        send(8'h42, 16'h0500);
        check_all("R6 power mask");
        // R7 transparent follows CODE
        send(8'h61, 16'h0200);
        send(8'h01, 16'h5550);
        check_all("R7 transparent follows");
        send(8'h69, 16'h0000);
        send(8'h68, 16'h0000);
        check_all("R7 all latched");
        // R8 reference
        send(8'h75, 16'h0000);
        check_all("R8 reference");
        // R1 short and long frames discarded
        send_bits(8'h82, 16'h9990, 23);
        check_all("R1 23-bit frame");
        send_bits(8'h82, 16'h9990, 25);
        check_all("R1 25-bit frame");
        send(8'h81, 16'h0000);
        check_all("R1 code untouched");
        // R12 unassigned commands
        send(8'h90, 16'hFFF0);
        send(8'h4C, 16'h0F00);
        send(8'h78, 16'h0000);
        send(8'h52, 16'h0000);
        send(8'h62, 16'h0F00);
        send(8'h83, 16'hFFF0);
        check_all("R12 ignored outputs");
        send(8'h81, 16'h0000);
        check_all("R12 code untouched");
        // R10 load pin
        send(8'h00, 16'h3210);
        send(8'h03, 16'hCDE0);
        check_all("R10 before pulse");
        ldac_n = 1'b0;
        wait_clk(4);
        ldac_n = 1'b1;
        wait_clk(4);
        for (int i = 0; i < NCH; i++) m_dac[i] = m_code[i];
        check_all("R10 load pin");
        // R11 clear pin
        clr_n = 1'b0;
        wait_clk(4);
        clr_n = 1'b1;
        wait_clk(4);
        for (int i = 0; i < NCH; i++) begin m_code[i] = '0; m_dac[i] = '0; end
        check_all("R11 clear pin");
        send(8'h81, 16'h0000);
        check_all("R11 code cleared");
        // R9 soft clear and soft reset
        send(8'h82, 16'h8880);
        send(8'h69, 16'h0000);
        send(8'h50, 16'h0000);
        check_all("R9 soft clear");
        send(8'h43, 16'h0F00);
        send(8'h80, 16'h1110);
        send(8'h51, 16'h0000);
        check_all("R9 soft reset");

        // Random mix
        for (int n = 0; n < 120; n++) begin
            logic [7:0] c;
            logic [15:0] d;
            c = pick_cmd();
            d = 16'($urandom_range(0, 65535));
            send(c, d);
            check_all("R2 random mix");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule